// File: doc/BRIEF.md
# Single-Shot Edge Capture Period Timer

This block measures the time between two qualifying edges of an external input pin. A 16-bit counter advances on ticks from a power-of-two prescaler driven by the system clock. Software selects which pin edges qualify, chooses the prescale, and optionally supplies a reload value. It then pulses `arm`.

After `arm`, the counter stays frozen until the first qualifying edge. That edge starts the measurement and, if reload is enabled, loads the counter. The next qualifying edge does three things: it copies the count into the capture register, it reloads the counter, and it sets the completion flag. In single-shot mode the timer then stops. In continuous mode it keeps capturing on every later qualifying edge.

If the counter wraps past its maximum before a closing edge arrives, the overflow flag is set and the timer stops without touching the capture register. The pin is synchronized before edge detection, so measured periods are whole numbers of timer ticks. All control and status pins are plain levels or single-cycle pulses. The block has no streaming interface and no back-pressure.

Top module: `period_capture_timer`

## Requirements
- R1: After reset, `capture_val` and `count_val` read 0000h, and `irq`, `done_flag`, `ovf_flag` and `running` are all 0.
- R2: `edge_sel` selects the qualifying edges: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. With 2'b00, an armed timer never starts and never completes.
- R3: In single-shot mode, the first qualifying edge after `arm` starts the measurement. The second stores the elapsed tick count in `capture_val`, sets `done_flag` and stops the timer (`running` = 0).
- R4: Between `arm` and the first qualifying edge, `count_val` does not change, and non-qualifying pin edges have no effect.
- R5: With `reload_en` = 1, each starting edge and each capturing edge load `reload_val` into the counter, so the capture equals `reload_val` plus the ticks in the period. With `reload_en` = 0, counting continues from the current count, and the capture equals that count plus the ticks.
- R6: `prescale` = p gives one timer tick every 2^p clocks (3'b000 divides by 1). The prescaler restarts on `arm`.
- R7: `irq` equals `done_flag` AND `irq_en`. `done_flag` stays set until an `irq_clr` pulse, which also clears `ovf_flag`.
- R8: If a tick occurs while the count is FFFFh during a measurement, the counter wraps to 0000h, `ovf_flag` and `done_flag` are set, the timer stops, and `capture_val` is left unchanged.
- R9: With `single_shot` = 0, every qualifying edge after the starting edge captures and reloads, and the timer keeps running.
- R10: Once stopped, the timer ignores pin edges: `capture_val` and `count_val` hold until the next `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous measured signal |
| arm | input | 1 | One-cycle pulse; waits for the first qualifying edge |
| edge_sel | input | 2 | Qualifying edge select (bit 0 rising, bit 1 falling) |
| prescale | input | 3 | Tick divider exponent, divide by 2^prescale |
| reload_en | input | 1 | Load `reload_val` on start and capture edges |
| single_shot | input | 1 | 1: stop after the first capture; 0: keep capturing |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | One-cycle pulse clearing `done_flag` and `ovf_flag` |
| reload_val | input | 16 | Counter reload value |
| capture_val | output | 16 | Last captured count |
| count_val | output | 16 | Live counter value |
| irq | output | 1 | Interrupt request |
| done_flag | output | 1 | Completion flag (capture or overflow) |
| ovf_flag | output | 1 | Counter wrapped before a closing edge |
| running | output | 1 | Armed or measuring |

## Verification
The bench covers rising, falling and both-edge selection with asymmetric high and low times. A design that decoded the edges wrongly would capture the wrong half or the full period. It also arms the timer mid-period and sends a non-qualifying edge. A design that counted before the starting edge would return an inflated period.

Prescaled runs catch an off-by-one in the tick divider. A reload starting just below FFFFh forces a wrap, which catches a design that captures on overflow or keeps running. Edges arriving after completion catch a timer that fails to stop, and the continuous-mode run catches one that halts after its first capture.

// File: rtl/pct_pkg.sv
package pct_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MEAS = 2'd2,
    ST_DONE = 2'd3
  } pct_state_e;
endpackage

// File: rtl/pct_pin_sync.sv
module pct_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= pin_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
  assign fall = ~chain_q[STAGES-1] & last_q;

  // R2: a detected rising edge cannot repeat on the next cycle
  a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pct_prescaler.sv
module pct_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PSC_W-1:0] psel,
  output logic             tick
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = (DIV_W'(1) << psel) - DIV_W'(1);
    tick = (div_q & mask) == mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (clr) div_q <= '0;
    else          div_q <= div_q + DIV_W'(1);
  end

  // R6: with division above 1, ticks never land on adjacent clocks
  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psel != '0 && !clr) |=> (!tick || psel != $past(psel)));
endmodule

// File: rtl/pct_capture_core.sv
module pct_capture_core
  import pct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             tick,
  input  logic             edge_hit,
  input  logic             reload_en,
  input  logic             single_shot,
  input  logic             irq_clr,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] capture_q,
  output logic [CNT_W-1:0] count_q,
  output logic             done_q,
  output logic             ovf_q,
  output pct_state_e       state_q
);
  logic [CNT_W-1:0] count_inc;
  logic             wrap;
  logic             done_set;
  logic             ovf_set;

  always_comb begin
    count_inc = count_q + CNT_W'(tick);
    wrap      = tick && (count_q == {CNT_W{1'b1}});
    done_set  = !arm && (state_q == ST_MEAS) && (wrap || edge_hit);
    ovf_set   = !arm && (state_q == ST_MEAS) && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      count_q   <= '0;
      capture_q <= '0;
    end else if (arm) begin
      state_q <= ST_WAIT;
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (edge_hit) begin
            state_q <= ST_MEAS;
            if (reload_en) count_q <= reload_val;
          end
        end
        ST_MEAS: begin
          if (wrap) begin
            count_q <= '0;
            state_q <= ST_DONE;
          end else if (edge_hit) begin
            capture_q <= count_inc;
            count_q   <= reload_en ? reload_val : count_inc;
            if (single_shot) state_q <= ST_DONE;
          end else begin
            count_q <= count_inc;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (done_set)     done_q <= 1'b1;
      else if (irq_clr) done_q <= 1'b0;
      if (ovf_set)      ovf_q  <= 1'b1;
      else if (irq_clr) ovf_q  <= 1'b0;
    end
  end

  // R4: frozen counter while waiting for the starting edge
  a_r4_hold_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !arm && !edge_hit) |=> $stable(count_q));
  // R8: wrap flags overflow and leaves the capture alone
  a_r8_wrap_keeps_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MEAS && !arm && wrap) |=> ($stable(capture_q) && ovf_q && state_q == ST_DONE));
  // R3: a stopped timer stays stopped until re-armed
  a_r3_stays_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !arm) |=> state_q == ST_DONE);
  // R10: capture only moves during a measurement
  a_r10_capture_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_MEAS) |=> $stable(capture_q));
  // R7: completion flag only rises out of a measurement
  a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(state_q) == ST_MEAS);
endmodule

// File: rtl/period_capture_timer.sv
module period_capture_timer
  import pct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             arm,
  input  logic [1:0]       edge_sel,
  input  logic [PSC_W-1:0] prescale,
  input  logic             reload_en,
  input  logic             single_shot,
  input  logic             irq_en,
  input  logic             irq_clr,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] capture_val,
  output logic [CNT_W-1:0] count_val,
  output logic             irq,
  output logic             done_flag,
  output logic             ovf_flag,
  output logic             running
);
  logic       pin_rise;
  logic       pin_fall;
  logic       tick;
  logic       edge_hit;
  pct_state_e state;

  pct_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_in(pin_in),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  pct_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (arm),
    .psel (prescale),
    .tick (tick)
  );

  assign edge_hit = (edge_sel[0] & pin_rise) | (edge_sel[1] & pin_fall);

  pct_capture_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .tick       (tick),
    .edge_hit   (edge_hit),
    .reload_en  (reload_en),
    .single_shot(single_shot),
    .irq_clr    (irq_clr),
    .reload_val (reload_val),
    .capture_q  (capture_val),
    .count_q    (count_val),
    .done_q     (done_flag),
    .ovf_q      (ovf_flag),
    .state_q    (state)
  );

  assign irq     = done_flag & irq_en;
  assign running = (state == ST_WAIT) || (state == ST_MEAS);

  // R2: with no edge selected, an armed timer never leaves the wait state
  a_r2_none_never_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && edge_sel == 2'b00 && !arm) |=> state == ST_WAIT);
endmodule

// File: tb/period_capture_timer_bench.sv
module period_capture_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0;
  logic        arm = 1'b0;
  logic [1:0]  edge_sel = 2'b01;
  logic [2:0]  prescale = 3'd0;
  logic        reload_en = 1'b1;
  logic        single_shot = 1'b1;
  logic        irq_en = 1'b1;
  logic        irq_clr = 1'b0;
  logic [15:0] reload_val = 16'h0000;
  logic [15:0] capture_val;
  logic [15:0] count_val;
  logic        irq;
  logic        done_flag;
  logic        ovf_flag;
  logic        running;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  period_capture_timer u_period_capture_timer (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .arm(arm),
    .edge_sel(edge_sel), .prescale(prescale), .reload_en(reload_en),
    .single_shot(single_shot), .irq_en(irq_en), .irq_clr(irq_clr),
    .reload_val(reload_val), .capture_val(capture_val), .count_val(count_val),
    .irq(irq), .done_flag(done_flag), .ovf_flag(ovf_flag), .running(running)
  );

  typedef struct packed {
    logic [1:0]  esel;
    logic [2:0]  psc;
    logic [15:0] rld;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [15:0] exp;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'b01, 3'd0, 16'h0000, 8'd10, 8'd6,  16'd16},
    '{2'b10, 3'd0, 16'h0000, 8'd3,  8'd9,  16'd12},
    '{2'b11, 3'd0, 16'h0000, 8'd7,  8'd5,  16'd7},
    '{2'b01, 3'd2, 16'h0000, 8'd12, 8'd8,  16'd5},
    '{2'b10, 3'd0, 16'd100,  8'd4,  8'd4,  16'd108},
    '{2'b01, 3'd3, 16'h0000, 8'd16, 8'd16, 16'd4},
    '{2'b11, 3'd1, 16'h0020, 8'd6,  8'd10, 16'h0023}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_arm();
    arm = 1'b1; wait_clk(1); arm = 1'b0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1; wait_clk(1); irq_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    wait_clk(3);
    // R1 reset state
    check("R1 capture", 32'(capture_val), 32'h0);
    check("R1 count", 32'(count_val), 32'h0);
    check("R1 flags", {28'h0, irq, done_flag, ovf_flag, running}, 32'h0);
    rst_n = 1'b1;
    wait_clk(2);

    // Vector walk: R2 edge select, R3 single shot, R5 reload, R6 prescale, R10 ignore later edges
    for (int i = 0; i < NVEC; i++) begin
      pin_in = 1'b0;
      pulse_clr();
      edge_sel = VECS[i].esel; prescale = VECS[i].psc; reload_val = VECS[i].rld;
      reload_en = 1'b1; single_shot = 1'b1; irq_en = 1'b1;
      pulse_arm();
      wait_clk(4);
      for (int k = 0; k < 3; k++) begin
        pin_in = 1'b1; wait_clk(int'(VECS[i].hi));
        pin_in = 1'b0; wait_clk(int'(VECS[i].lo));
      end
      wait_clk(6);
      check($sformatf("R3 R6 capture vec%0d", i), 32'(capture_val), 32'(VECS[i].exp));
      check($sformatf("R5 count reloaded vec%0d", i), 32'(count_val), 32'(VECS[i].rld));
      check($sformatf("R7 irq vec%0d", i), {30'h0, irq, running}, 32'h2);
    end

    // R4: arm mid-period without reload; rising edge is not qualifying
    pulse_clr();
    edge_sel = 2'b10; prescale = 3'd0; reload_en = 1'b0;
    pulse_arm();
    wait_clk(2);
    pin_in = 1'b1;
    wait_clk(20);
    check("R4 count frozen", 32'(count_val), 32'h0020);
    check("R4 running no done", {30'h0, running, done_flag}, 32'h2);
    pin_in = 1'b0; wait_clk(5);
    pin_in = 1'b1; wait_clk(5);
    pin_in = 1'b0; wait_clk(6);
    check("R5 no-reload capture", 32'(capture_val), 32'h002A);
    check("R5 no-reload count", 32'(count_val), 32'h002A);

    // R7: enable gates irq, clear drops the flag
    irq_en = 1'b0;
    wait_clk(1);
    check("R7 irq masked", {30'h0, irq, done_flag}, 32'h1);
    pulse_clr();
    check("R7 flag cleared", 32'(done_flag), 32'h0);

    // R2: no edges selected
    edge_sel = 2'b00; irq_en = 1'b1;
    pulse_arm();
    for (int k = 0; k < 4; k++) begin
      pin_in = ~pin_in; wait_clk(5);
    end
    check("R2 none still waiting", {30'h0, running, done_flag}, 32'h2);
    check("R2 none capture", 32'(capture_val), 32'h002A);

    // R9: continuous capture
    pin_in = 1'b0;
    edge_sel = 2'b01; reload_en = 1'b1; reload_val = 16'h0000; single_shot = 1'b0;
    pulse_arm();
    wait_clk(4);
    pin_in = 1'b1; wait_clk(4);
    pin_in = 1'b0; wait_clk(4);
    pin_in = 1'b1; wait_clk(5);
    check("R9 first capture", 32'(capture_val), 32'd8);
    check("R9 still running", {30'h0, running, done_flag}, 32'h3);
    pulse_clr();
    pin_in = 1'b0; wait_clk(6);
    pin_in = 1'b1; wait_clk(5);
    check("R9 second capture", 32'(capture_val), 32'd12);
    check("R9 flag again", {30'h0, running, done_flag}, 32'h3);

    // R8: overflow before closing edge
    single_shot = 1'b1; reload_val = 16'hFFF0;
    pulse_clr();
    pulse_arm();
    pin_in = 1'b0; wait_clk(4);
    pin_in = 1'b1; wait_clk(40);
    check("R8 flags", {28'h0, ovf_flag, done_flag, running, irq}, 32'hD);
    check("R8 capture kept", 32'(capture_val), 32'd12);
    check("R8 count wrapped", 32'(count_val), 32'h0);

    // R10: stopped timer ignores edges
    for (int k = 0; k < 4; k++) begin
      pin_in = ~pin_in; wait_clk(6);
    end
    check("R10 capture held", 32'(capture_val), 32'd12);
    check("R10 count held", 32'(count_val), 32'h0);
    pulse_clr();
    check("R7 R8 clear both", {30'h0, ovf_flag, done_flag}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule